// File: doc/BRIEF.md
# UART Modem Status Register

This block keeps the modem status byte of a 16550-style serial port. Each clock it takes a sample of the four modem handshake lines (clear to send, data set ready, ring indicator, carrier detect) and stores it as the upper nibble of the status byte. It sets a sticky change bit in the lower nibble for each line whose level has moved. The ring line is the exception: its change bit records only a trailing edge, where the line falls from 1 to 0. A read strobe returns the byte in the cycle it is asserted and clears the change bits at the next clock edge. A change detected at that same edge survives the clear.

In loopback mode the external lines are ignored. The four modem control outputs of the port are fed back in their place, so that software can exercise the status path without a cable. The block also drives a change flag that interrupt logic uses as its modem-status source. The line inputs are expected to be synchronised already. The reset is synchronous and active high.

Top module: `uart_modem_status`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the status byte is 0xB0 (carrier detect, data set ready and clear to send high, ring low, no change bits) and the change flag is low.
- R2: One clock after the lines are sampled, the status byte carries the current line levels in its upper nibble: clear to send in bit 4, data set ready in bit 5, ring in bit 6 and carrier detect in bit 7.
- R3: A change in either direction of clear to send, data set ready or carrier detect sets change bit 0, 1 or 3 respectively, in the same cycle that the new level appears.
- R4: Ring change bit 2 is set only when the ring level goes from 1 to 0. A rising ring level leaves it unchanged.
- R5: Change bits are sticky. Once set, a change bit stays set until a read, even if the line returns to its former level.
- R6: A read strobe presents the byte as it stands in the cycle of the strobe. At the next edge the change bits that are not re-set by a new change are cleared.
- R7: A line change detected at the same edge as a read sets its change bit after the clear, so that change is not lost.
- R8: With loopback high, control bit 1 is seen as clear to send, bit 0 as data set ready, bit 2 as ring and bit 3 as carrier detect. Changes on the external lines have no effect on the byte.
- R9: The change flag is high exactly when at least one change bit of the status byte is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cts_i | input | 1 | Clear to send line level |
| dsr_i | input | 1 | Data set ready line level |
| ri_i | input | 1 | Ring indicator line level |
| dcd_i | input | 1 | Carrier detect line level |
| loop_i | input | 1 | Loopback mode select |
| ctl_i | input | 4 | Modem control outputs: bit 0 terminal ready, bit 1 request to send, bit 2 user output 1, bit 3 user output 2 |
| rd_i | input | 1 | Read strobe for the status byte |
| status_o | output | 8 | Status byte: line levels in bits 7:4, change bits in bits 3:0 |
| chg_o | output | 1 | Modem status change flag |

## Verification
The bench builds the block with its default parameters. These are four lines, a reset pattern with the ring low and the others high, and trailing-edge detection selected for the ring line only. With these values the reset byte 0xB0 and both kinds of edge detector can be observed at the ports. Because each line has its own generated cell, the vector table can raise and drop several lines in one step. This exercises delta accumulation across steps, a read in the same cycle as a change, and every loopback mapping, including entry into and exit from loopback.

// File: rtl/uart_msr_pkg.sv
package uart_msr_pkg;
  localparam int LINES   = 4;
  localparam int STATW   = 2 * LINES;
  // line positions inside a line vector (and inside each status nibble)
  localparam int L_CTS   = 0;
  localparam int L_DSR   = 1;
  localparam int L_RI    = 2;
  localparam int L_DCD   = 3;
  // modem control bit positions
  localparam int C_DTR   = 0;
  localparam int C_RTS   = 1;
  localparam int C_OUT1  = 2;
  localparam int C_OUT2  = 3;
  typedef logic [LINES-1:0] line_vec_t;
endpackage

// File: rtl/msr_line_source.sv
module msr_line_source
  import uart_msr_pkg::*;
(
  input  logic      loop_i,
  input  line_vec_t ext_i,
  input  line_vec_t ctl_i,
  output line_vec_t sel_o
);
  line_vec_t looped;

  always_comb begin
    looped        = '0;
    looped[L_CTS] = ctl_i[C_RTS];
    looped[L_DSR] = ctl_i[C_DTR];
    looped[L_RI]  = ctl_i[C_OUT1];
    looped[L_DCD] = ctl_i[C_OUT2];
  end

  // R8: external lines are ignored in loopback
  assign sel_o = loop_i ? looped : ext_i;
endmodule

// File: rtl/msr_delta_cell.sv
module msr_delta_cell #(
  parameter logic RESET_VAL  = 1'b0,
  parameter bit   TRAIL_ONLY = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic rd_i,
  output logic state_o,
  output logic delta_o,
  output logic delta_nx_o
);
  logic state_q;
  logic delta_q;
  logic hit;

  generate
    if (TRAIL_ONLY) begin : g_trail
      assign hit = state_q & ~line_i;
    end else begin : g_any
      assign hit = state_q ^ line_i;
    end
  endgenerate

  // R5/R6/R7: sticky, cleared by read, new change wins over the clear
  assign delta_nx_o = (delta_q & ~rd_i) | hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RESET_VAL;
      delta_q <= 1'b0;
    end else begin
      state_q <= line_i;
      delta_q <= delta_nx_o;
    end
  end

  assign state_o = state_q;
  assign delta_o = delta_q;

  // R5: a set delta survives a cycle without a read
  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(delta_q) && !$past(rd_i) && !$past(rst)) |-> delta_q);

  // R6: a read with no new change leaves the delta clear
  p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_i) && !$past(rst) && $stable(state_q)) |-> !delta_q);

  generate
    if (TRAIL_ONLY) begin : g_chk_trail
      // R4: a fall is flagged, a rise changes nothing
      p_fall_sets_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(state_q) && !$past(rst)) |-> delta_q);
      p_rise_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(state_q) && !$past(rd_i) && !$past(rst)) |-> (delta_q == $past(delta_q)));
    end else begin : g_chk_any
      // R3: any movement is flagged
      p_move_sets_r3: assert property (@(posedge clk) disable iff (rst)
        (!$stable(state_q) && !$past(rst)) |-> delta_q);
    end
  endgenerate
endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status
  import uart_msr_pkg::*;
#(
  parameter logic [LINES-1:0] RESET_LINES = 4'b1011,
  parameter logic [LINES-1:0] TRAIL_MASK  = 4'b0100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cts_i,
  input  logic             dsr_i,
  input  logic             ri_i,
  input  logic             dcd_i,
  input  logic             loop_i,
  input  logic [LINES-1:0] ctl_i,
  input  logic             rd_i,
  output logic [STATW-1:0] status_o,
  output logic             chg_o
);
  line_vec_t ext_lines;
  line_vec_t sel_lines;
  line_vec_t state;
  line_vec_t delta;
  line_vec_t delta_nx;
  logic      chg_q;

  always_comb begin
    ext_lines        = '0;
    ext_lines[L_CTS] = cts_i;
    ext_lines[L_DSR] = dsr_i;
    ext_lines[L_RI]  = ri_i;
    ext_lines[L_DCD] = dcd_i;
  end

  msr_line_source u_src (
    .loop_i (loop_i),
    .ext_i  (ext_lines),
    .ctl_i  (ctl_i),
    .sel_o  (sel_lines)
  );

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      msr_delta_cell #(
        .RESET_VAL  (RESET_LINES[i]),
        .TRAIL_ONLY (TRAIL_MASK[i])
      ) u_cell (
        .clk        (clk),
        .rst        (rst),
        .line_i     (sel_lines[i]),
        .rd_i       (rd_i),
        .state_o    (state[i]),
        .delta_o    (delta[i]),
        .delta_nx_o (delta_nx[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) chg_q <= 1'b0;
    else     chg_q <= |delta_nx;
  end

  assign status_o = {state, delta};
  assign chg_o    = chg_q;

  // R9: flag agrees with the change nibble
  p_flag_match_r9: assert property (@(posedge clk) disable iff (rst)
    chg_o == (|status_o[LINES-1:0]));

  // R1: first cycle out of reset shows the reset pattern
  p_reset_val_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (status_o == {RESET_LINES, {LINES{1'b0}}} && !chg_o));

  // R8: loopback places the control bits on the line levels
  p_loop_map_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(loop_i) && !$past(rst)) |->
      (status_o[LINES+L_CTS] == $past(ctl_i[C_RTS]) &&
       status_o[LINES+L_DSR] == $past(ctl_i[C_DTR]) &&
       status_o[LINES+L_RI]  == $past(ctl_i[C_OUT1]) &&
       status_o[LINES+L_DCD] == $past(ctl_i[C_OUT2])));

  // R2: outside loopback the levels follow the pins
  p_follow_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(loop_i) && !$past(rst)) |->
      (status_o[STATW-1:LINES] == $past({dcd_i, ri_i, dsr_i, cts_i})));
endmodule

// File: tb/uart_modem_status_test.sv
module uart_modem_status_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cts_i = 1'b1, dsr_i = 1'b1, ri_i = 1'b0, dcd_i = 1'b1;
  logic       loop_i = 1'b0;
  logic [3:0] ctl_i = 4'h0;
  logic       rd_i = 1'b0;
  logic [7:0] status_o;
  logic       chg_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  uart_modem_status uut (
    .clk(clk), .rst(rst),
    .cts_i(cts_i), .dsr_i(dsr_i), .ri_i(ri_i), .dcd_i(dcd_i),
    .loop_i(loop_i), .ctl_i(ctl_i), .rd_i(rd_i),
    .status_o(status_o), .chg_o(chg_o)
  );

  // entry: loop, ctl[3:0], lines {dcd,ri,dsr,cts}, rd, expected byte, expected flag
  localparam int NV = 14;
  localparam logic [18:0] TBL [0:NV-1] = '{
    {1'b0, 4'h0, 4'b1010, 1'b0, 8'hA1, 1'b1},  // R3 cts falls
    {1'b0, 4'h0, 4'b1010, 1'b1, 8'hA0, 1'b0},  // R6 read clears
    {1'b0, 4'h0, 4'b1110, 1'b0, 8'hE0, 1'b0},  // R4 ring rise not flagged
    {1'b0, 4'h0, 4'b1010, 1'b0, 8'hA4, 1'b1},  // R4 ring fall flagged
    {1'b0, 4'h0, 4'b0010, 1'b0, 8'h2C, 1'b1},  // R5 accumulate
    {1'b0, 4'h0, 4'b0000, 1'b1, 8'h02, 1'b1},  // R7 change with read
    {1'b0, 4'h0, 4'b0000, 1'b1, 8'h00, 1'b0},  // R6
    {1'b0, 4'h0, 4'b1111, 1'b0, 8'hFB, 1'b1},  // R2 R3 all rise
    {1'b0, 4'h0, 4'b1111, 1'b1, 8'hF0, 1'b0},  // R9 flag drops
    {1'b1, 4'h0, 4'b1111, 1'b0, 8'h0F, 1'b1},  // R8 enter loopback
    {1'b1, 4'h2, 4'b0000, 1'b1, 8'h11, 1'b1},  // R8 rts -> cts
    {1'b1, 4'hD, 4'b1111, 1'b1, 8'hEB, 1'b1},  // R8 dtr/out1/out2
    {1'b1, 4'hD, 4'b0000, 1'b1, 8'hE0, 1'b0},  // R8 external ignored
    {1'b0, 4'hD, 4'b1110, 1'b0, 8'hE0, 1'b0}   // R8 leave loopback
  };

  task automatic check(input string req, input logic [7:0] exp_st, input logic exp_chg);
    n_checks++;
    if (status_o !== exp_st || chg_o !== exp_chg) begin
      n_errors++;
      $display("FAIL %s: status=%02h chg=%0b expected status=%02h chg=%0b",
               req, status_o, chg_o, exp_st, exp_chg);
    end
  endtask

  task automatic set_lines(input logic [3:0] l);
    {dcd_i, ri_i, dsr_i, cts_i} = l;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 8'hB0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", 8'hB0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      loop_i = TBL[i][18];
      ctl_i  = TBL[i][17:14];
      set_lines(TBL[i][13:10]);
      rd_i   = TBL[i][9];
      @(negedge clk);
      check($sformatf("R2/R3/R4/R5/R6/R7/R8/R9 vector %0d", i), TBL[i][8:1], TBL[i][0]);
    end
    rd_i = 1'b0;

    // R6: read strobe returns the byte before the clear
    set_lines(4'b1010);
    @(negedge clk);
    check("R4 ring fall before read", 8'hA4, 1'b1);
    rd_i = 1'b1;
    #1;
    check("R6 read data in strobe cycle", 8'hA4, 1'b1);
    @(negedge clk);
    rd_i = 1'b0;
    check("R6 cleared after read", 8'hA0, 1'b0);

    // R5: line returns to old level, delta stays
    set_lines(4'b1011);
    @(negedge clk);
    set_lines(4'b1010);
    @(negedge clk);
    check("R5 delta held after return", 8'hA1, 1'b1);

    // R1: reset in mid run with deltas pending
    set_lines(4'b0000);
    @(negedge clk);
    rst = 1'b1;
    set_lines(4'b1011);
    @(negedge clk);
    check("R1 mid-run reset", 8'hB0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 quiet after release", 8'hB0, 1'b0);

    finish_run();
  end
endmodule